// File: doc/BRIEF.md
# Floppy Controller Transfer Sequencer

This block sits on the host side of a floppy disk controller and runs single-sector operations against it. The controller is reached through two words. One is a command/status word and the other is a data word. The controller signals that it wants the next parameter word by raising a transfer-request bit in its status word. The sequencer accepts one request at a time: read, write, format or read-status. It splits each request into ordered controller commands. Every parameter word is paced by the transfer-request bit. The controller's interrupt marks the end of each command.

A read runs a read command first and then a buffer-empty command, which moves the sector to memory. A write runs a buffer-fill command first and then the write command. A request longer than one sector repeats this pair once per sector. Each repeat advances the buffer address by one sector size, and the sector number wraps into the next track. The block keeps three pieces of status: the disk density, whether the drive is absent, and the deleted-data mark of the last sector read. It also keeps a one-shot flag that makes the next write a deleted-data write.

Top module: `fdc_xfer_seq`

## Requirements
- R1: `ctl_state` is 8 after reset and whenever the block is idle. While a command phase is in progress it shows that phase: 1 read, 2 empty, 3 fill, 4 write, 5 format, 6 status.
- R2: A read request writes the read command word and then waits for status bit 7 (transfer request) twice. It sends the sector number on the data word after the first wait and the track number after the second. The data word is written only while bit 7 is set.
- R3: The interrupt that ends a read issues the empty command. The empty command sends the word count and then the low 16 bits of the buffer address, each after a transfer request. The word count is this sector's byte count divided by two.
- R4: A write request first issues the fill command with the same word-count and address parameters. The write command, followed by the sector and then the track, is issued only after the interrupt that ends the fill.
- R5: A pulse on `wdds_arm` makes the next write command use function 6 (deleted-data write) in place of function 2. The flag is then cleared, so later writes use function 2 again.
- R6: At the interrupt that ends a read, bit 6 of `db_in` is latched onto `ddmark`.
- R7: A format request writes the format command, waits for a transfer request, and sends 0x0049. It sets `dens_dbl` from `req_den` and completes without error at its interrupt.
- R8: Before the first command of each sector, if `cs_in` equals exactly 0x0800, the block first writes the init word 0x4000. It then waits for status bit 5 (done) before issuing the command.
- R9: At the interrupt that ends a status read: if `db_in` bit 7 (ready) is clear, the block sets `drive_absent` and completes with an error. Otherwise it clears `drive_absent`, sets `dens_dbl` from `db_in` bit 5, and completes without error.
- R10: One sector is 128 bytes in single density and 256 bytes in double density. A request covers `req_bytes` bytes over as many sectors as it needs. Each later sector moves the buffer address on by one sector size and adds one to the sector number. Sector 26 is followed by sector 1 of the next track. `done_o` pulses after the last sector only.
- R11: Each command word has bit 0 set (go). It carries the function code in bits 3:1 (fill 0, empty 1, write 2, read 3, format 4, status 5, deleted write 6). It also carries drive select in bit 4, interrupt enable in bit 6, double density in bit 8 and buffer address bits 17:16 in bits 13:12.
- R12: If status bit 15 (error) is set at an interrupt outside a status read, the request ends: `done_o` pulses with `done_err` set and `ctl_state` returns to 8.
- R13: An interrupt that arrives while the block is idle makes it write the init word 0x4000. It then stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_op | input | 2 | 0 read, 1 write, 2 format, 3 status |
| req_drive | input | 1 | Drive select |
| req_den | input | 1 | Density for a format request |
| req_addr | input | 18 | Memory buffer address |
| req_bytes | input | 16 | Bytes to move |
| req_sector | input | 5 | First sector number (1..26) |
| req_track | input | 7 | First track number |
| req_ready | output | 1 | Idle and able to take a request |
| wdds_arm | input | 1 | Arms one deleted-data write |
| done_o | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Completion carried an error (valid with `done_o`) |
| ddmark | output | 1 | Deleted-data mark of the last read |
| dens_dbl | output | 1 | Current density is double |
| drive_absent | output | 1 | Last status read found no ready drive |
| ctl_state | output | 4 | Current controller phase code |
| cs_in | input | 16 | Controller status word |
| db_in | input | 16 | Controller data word |
| irq | input | 1 | Controller interrupt pulse |
| cs_wr | output | 1 | Write strobe for the command word |
| db_wr | output | 1 | Write strobe for the data word |
| wr_data | output | 16 | Data for either write strobe |

## Verification
The hardest case to reach is the second sector of a multi-sector, double-density write. That one case covers the sector wrap, the address step, the shortened last word count and the end of the one-shot deleted-data flag. Reaching it takes three steps. A status read first reports double density. The deleted-data flag is then armed. Finally, a 300-byte write starts at sector 26. The behavioural controller in the bench raises transfer requests two cycles after each write, and its interrupts let the second fill/write pair run after the first.

// File: rtl/fdc_seq_pkg.sv
// Shared codes for the floppy transfer sequencer.
// Assumes a 16-bit controller word and the bit layout given in the brief.
package fdc_seq_pkg;

    localparam int WORD_W = 16;

    // Status word bit positions
    localparam int CSB_DONE = 5;
    localparam int CSB_TREQ = 7;
    localparam int CSB_ERR  = 15;

    // Data word status bit positions
    localparam int DBB_DEN   = 5;
    localparam int DBB_DMARK = 6;
    localparam int DBB_READY = 7;

    localparam logic [WORD_W-1:0] VOL_LOST  = 16'h0800;
    localparam logic [WORD_W-1:0] INIT_WORD = 16'h4000;
    localparam logic [WORD_W-1:0] FMT_KEY   = 16'h0049;

    // Controller function codes (bits 3:1 of the command word)
    localparam logic [2:0] FN_FILL   = 3'd0;
    localparam logic [2:0] FN_EMPTY  = 3'd1;
    localparam logic [2:0] FN_WRITE  = 3'd2;
    localparam logic [2:0] FN_READ   = 3'd3;
    localparam logic [2:0] FN_FORMAT = 3'd4;
    localparam logic [2:0] FN_STATUS = 3'd5;
    localparam logic [2:0] FN_WDEL   = 3'd6;
    localparam logic [2:0] FN_ERRDMP = 3'd7;

    typedef enum logic [3:0] {
        PH_READ   = 4'd1,
        PH_EMPTY  = 4'd2,
        PH_FILL   = 4'd3,
        PH_WRITE  = 4'd4,
        PH_FORMAT = 4'd5,
        PH_STATUS = 4'd6,
        PH_ERRDMP = 4'd7,
        PH_IDLE   = 4'd8
    } phase_e;

    typedef enum logic [1:0] {
        OP_READ   = 2'd0,
        OP_WRITE  = 2'd1,
        OP_FORMAT = 2'd2,
        OP_STATUS = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_VCHK,
        ST_INITW,
        ST_CMD,
        ST_P1,
        ST_P2,
        ST_WAIT
    } step_e;

endpackage

// File: rtl/fdc_cmd_word.sv
// Builds a controller command word from its fields.
// Purely combinational. Interrupt enable and go are always set.
module fdc_cmd_word
    import fdc_seq_pkg::*;
(
    input  logic [2:0]        func,
    input  logic              drive,
    input  logic              den,
    input  logic [1:0]        addr_hi,
    output logic [WORD_W-1:0] word
);
    // Pack the fields into their fixed positions
    always_comb begin
        word        = '0;
        word[0]     = 1'b1;
        word[3:1]   = func;
        word[4]     = drive;
        word[6]     = 1'b1;
        word[8]     = den;
        word[13:12] = addr_hi;
    end
endmodule

// File: rtl/fdc_xfer_track.sv
// Keeps the per-request transfer position: bytes left, buffer address,
// sector and track. Moves on by one sector on each adv pulse.
// Assumes adv is never pulsed while last is high.
module fdc_xfer_track #(
    parameter int ADDR_W      = 18,
    parameter int CNT_W       = 16,
    parameter int SEC_W       = 5,
    parameter int TRK_W       = 7,
    parameter int SEC_PER_TRK = 26,
    parameter int TRACKS      = 77
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              adv,
    input  logic              den,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [CNT_W-1:0]  ld_bytes,
    input  logic [SEC_W-1:0]  ld_sector,
    input  logic [TRK_W-1:0]  ld_track,
    output logic [ADDR_W-1:0] addr,
    output logic [SEC_W-1:0]  sector,
    output logic [TRK_W-1:0]  track,
    output logic [CNT_W-1:0]  wcount,
    output logic              last
);
    localparam logic [CNT_W-1:0] SD_BYTES = CNT_W'(128);
    localparam logic [CNT_W-1:0] DD_BYTES = CNT_W'(256);
    localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SEC_PER_TRK);
    localparam logic [TRK_W-1:0] TRK_LAST = TRK_W'(TRACKS - 1);

    logic [CNT_W-1:0] left_q;
    logic [CNT_W-1:0] nbps;
    logic [CNT_W-1:0] this_bytes;

    // Sector size and this sector's byte count
    always_comb begin
        nbps       = den ? DD_BYTES : SD_BYTES;
        last       = (left_q <= nbps);
        this_bytes = last ? left_q : nbps;
        wcount     = this_bytes >> 1;
    end

    // Position registers: load at request start, step per finished sector
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
            addr   <= '0;
            sector <= '0;
            track  <= '0;
        end else if (load) begin
            left_q <= ld_bytes;
            addr   <= ld_addr;
            sector <= ld_sector;
            track  <= ld_track;
        end else if (adv) begin
            left_q <= left_q - nbps;
            addr   <= addr + ADDR_W'(nbps);
            if (sector == SEC_LAST) begin
                sector <= SEC_W'(1);
                track  <= (track == TRK_LAST) ? '0 : track + TRK_W'(1);
            end else begin
                sector <= sector + SEC_W'(1);
            end
        end
    end
endmodule

// File: rtl/fdc_flag_bank.sv
// Holds the drive status flags: density, drive absent, the last deleted-data
// mark and the one-shot deleted-write request. Each has its own load strobe.
module fdc_flag_bank (
    input  logic clk,
    input  logic rst_n,
    input  logic dmark_ld,
    input  logic dmark_val,
    input  logic den_ld,
    input  logic den_val,
    input  logic abs_ld,
    input  logic abs_val,
    input  logic wdel_arm,
    input  logic wdel_use,
    output logic dmark,
    output logic den,
    output logic absent,
    output logic wdel
);
    // Status flags updated on their strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dmark  <= 1'b0;
            den    <= 1'b0;
            absent <= 1'b0;
        end else begin
            if (dmark_ld) dmark  <= dmark_val;
            if (den_ld)   den    <= den_val;
            if (abs_ld)   absent <= abs_val;
        end
    end

    // One-shot deleted-write flag: arm sets it, use clears it (arm wins)
    always_ff @(posedge clk) begin
        if (!rst_n)        wdel <= 1'b0;
        else if (wdel_arm) wdel <= 1'b1;
        else if (wdel_use) wdel <= 1'b0;
    end
endmodule

// File: rtl/fdc_xfer_seq.sv
// Floppy transfer sequencer top. Splits each request into ordered controller
// command phases. Parameter words are sent only while the controller asks for
// them, and each phase ends at the controller interrupt. Assumes one
// request at a time and an interrupt pulse that lasts one cycle.
module fdc_xfer_seq
    import fdc_seq_pkg::*;
#(
    parameter int ADDR_W      = 18,
    parameter int CNT_W       = 16,
    parameter int SEC_W       = 5,
    parameter int TRK_W       = 7,
    parameter int SEC_PER_TRK = 26,
    parameter int TRACKS      = 77
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic              req_drive,
    input  logic              req_den,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CNT_W-1:0]  req_bytes,
    input  logic [SEC_W-1:0]  req_sector,
    input  logic [TRK_W-1:0]  req_track,
    output logic              req_ready,
    input  logic              wdds_arm,
    output logic              done_o,
    output logic              done_err,
    output logic              ddmark,
    output logic              dens_dbl,
    output logic              drive_absent,
    output logic [3:0]        ctl_state,
    input  logic [WORD_W-1:0] cs_in,
    input  logic [WORD_W-1:0] db_in,
    input  logic              irq,
    output logic              cs_wr,
    output logic              db_wr,
    output logic [WORD_W-1:0] wr_data
);
    step_e  step_q, step_d;
    phase_e ph_q, ph_d;
    op_e    op_q;
    logic   drive_q;
    logic   done_d, err_d;

    logic              load, adv;
    logic [ADDR_W-1:0] cur_addr;
    logic [SEC_W-1:0]  cur_sec;
    logic [TRK_W-1:0]  cur_trk;
    logic [CNT_W-1:0]  wcount;
    logic              last_sec;

    logic dmark_ld, den_ld, den_val, abs_ld, abs_val, wdel_use, wdel;
    logic [2:0]        func;
    logic [WORD_W-1:0] cmd_word;
    logic [WORD_W-1:0] p1, p2;
    logic [1:0]        nparam;
    logic              accept;

    fdc_xfer_track #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .SEC_W(SEC_W), .TRK_W(TRK_W),
        .SEC_PER_TRK(SEC_PER_TRK), .TRACKS(TRACKS)
    ) u_track (
        .clk(clk), .rst_n(rst_n), .load(load), .adv(adv), .den(dens_dbl),
        .ld_addr(req_addr), .ld_bytes(req_bytes), .ld_sector(req_sector),
        .ld_track(req_track), .addr(cur_addr), .sector(cur_sec),
        .track(cur_trk), .wcount(wcount), .last(last_sec)
    );

    fdc_flag_bank u_flags (
        .clk(clk), .rst_n(rst_n),
        .dmark_ld(dmark_ld), .dmark_val(db_in[DBB_DMARK]),
        .den_ld(den_ld), .den_val(den_val),
        .abs_ld(abs_ld), .abs_val(abs_val),
        .wdel_arm(wdds_arm), .wdel_use(wdel_use),
        .dmark(ddmark), .den(dens_dbl), .absent(drive_absent), .wdel(wdel)
    );

    fdc_cmd_word u_cmd (
        .func(func), .drive(drive_q), .den(dens_dbl),
        .addr_hi(cur_addr[ADDR_W-1 -: 2]), .word(cmd_word)
    );

    // Function code, parameter words and parameter count of the current phase
    always_comb begin
        func   = FN_ERRDMP;
        p1     = '0;
        p2     = '0;
        nparam = 2'd0;
        case (ph_q)
            PH_READ:   begin func = FN_READ;  nparam = 2'd2; end
            PH_WRITE:  begin func = wdel ? FN_WDEL : FN_WRITE; nparam = 2'd2; end
            PH_EMPTY:  begin func = FN_EMPTY; nparam = 2'd2; end
            PH_FILL:   begin func = FN_FILL;  nparam = 2'd2; end
            PH_FORMAT: begin func = FN_FORMAT; nparam = 2'd1; p1 = FMT_KEY; end
            PH_STATUS: begin func = FN_STATUS; nparam = 2'd0; end
            default:   ;
        endcase
        if (ph_q == PH_READ || ph_q == PH_WRITE) begin
            p1 = WORD_W'(cur_sec);
            p2 = WORD_W'(cur_trk);
        end else if (ph_q == PH_EMPTY || ph_q == PH_FILL) begin
            p1 = WORD_W'(wcount);
            p2 = cur_addr[WORD_W-1:0];
        end
    end

    // The phase that opens each sector of a given operation
    function automatic phase_e first_phase(input op_e op);
        case (op)
            OP_READ:   first_phase = PH_READ;
            OP_WRITE:  first_phase = PH_FILL;
            OP_FORMAT: first_phase = PH_FORMAT;
            default:   first_phase = PH_STATUS;
        endcase
    endfunction

    assign req_ready = (step_q == ST_IDLE) && !irq;
    assign accept    = req_valid && req_ready;
    assign ctl_state = ph_q;

    // Step decisions, bus strobes and side-effect strobes
    always_comb begin
        step_d   = step_q;
        ph_d     = ph_q;
        done_d   = 1'b0;
        err_d    = 1'b0;
        cs_wr    = 1'b0;
        db_wr    = 1'b0;
        wr_data  = '0;
        load     = 1'b0;
        adv      = 1'b0;
        dmark_ld = 1'b0;
        den_ld   = 1'b0;
        den_val  = 1'b0;
        abs_ld   = 1'b0;
        abs_val  = 1'b0;
        wdel_use = 1'b0;
        case (step_q)
            ST_IDLE: begin
                if (irq) begin
                    cs_wr   = 1'b1;
                    wr_data = INIT_WORD;
                end else if (req_valid) begin
                    load   = 1'b1;
                    ph_d   = first_phase(op_e'(req_op));
                    step_d = ST_VCHK;
                    if (op_e'(req_op) == OP_FORMAT) begin
                        den_ld  = 1'b1;
                        den_val = req_den;
                    end
                end
            end
            ST_VCHK: begin
                if (cs_in == VOL_LOST) begin
                    cs_wr   = 1'b1;
                    wr_data = INIT_WORD;
                    step_d  = ST_INITW;
                end else begin
                    step_d = ST_CMD;
                end
            end
            ST_INITW: begin
                if (cs_in[CSB_DONE]) step_d = ST_CMD;
            end
            ST_CMD: begin
                cs_wr    = 1'b1;
                wr_data  = cmd_word;
                wdel_use = (ph_q == PH_WRITE) && wdel;
                step_d   = (nparam == 2'd0) ? ST_WAIT : ST_P1;
            end
            ST_P1: begin
                if (cs_in[CSB_TREQ]) begin
                    db_wr   = 1'b1;
                    wr_data = p1;
                    step_d  = (nparam == 2'd2) ? ST_P2 : ST_WAIT;
                end
            end
            ST_P2: begin
                if (cs_in[CSB_TREQ]) begin
                    db_wr   = 1'b1;
                    wr_data = p2;
                    step_d  = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (irq) begin
                    if (cs_in[CSB_ERR] && ph_q != PH_STATUS) begin
                        done_d = 1'b1;
                        err_d  = 1'b1;
                        ph_d   = PH_IDLE;
                        step_d = ST_IDLE;
                    end else begin
                        case (ph_q)
                            PH_READ: begin
                                dmark_ld = 1'b1;
                                ph_d     = PH_EMPTY;
                                step_d   = ST_CMD;
                            end
                            PH_FILL: begin
                                ph_d   = PH_WRITE;
                                step_d = ST_CMD;
                            end
                            PH_EMPTY, PH_WRITE: begin
                                if (last_sec) begin
                                    done_d = 1'b1;
                                    ph_d   = PH_IDLE;
                                    step_d = ST_IDLE;
                                end else begin
                                    adv    = 1'b1;
                                    ph_d   = first_phase(op_q);
                                    step_d = ST_VCHK;
                                end
                            end
                            PH_FORMAT: begin
                                done_d = 1'b1;
                                ph_d   = PH_IDLE;
                                step_d = ST_IDLE;
                            end
                            PH_STATUS: begin
                                abs_ld  = 1'b1;
                                abs_val = !db_in[DBB_READY];
                                den_ld  = db_in[DBB_READY];
                                den_val = db_in[DBB_DEN];
                                done_d  = 1'b1;
                                err_d   = !db_in[DBB_READY];
                                ph_d    = PH_IDLE;
                                step_d  = ST_IDLE;
                            end
                            default: begin
                                cs_wr   = 1'b1;
                                wr_data = INIT_WORD;
                                ph_d    = PH_IDLE;
                                step_d  = ST_IDLE;
                            end
                        endcase
                    end
                end
            end
            default: begin
                ph_d   = PH_IDLE;
                step_d = ST_IDLE;
            end
        endcase
    end

    // Sequencer state, request latch and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q   <= ST_IDLE;
            ph_q     <= PH_IDLE;
            op_q     <= OP_READ;
            drive_q  <= 1'b0;
            done_o   <= 1'b0;
            done_err <= 1'b0;
        end else begin
            step_q   <= step_d;
            ph_q     <= ph_d;
            done_o   <= done_d;
            done_err <= err_d;
            if (accept) begin
                op_q    <= op_e'(req_op);
                drive_q <= req_drive;
            end
        end
    end
endmodule

// File: rtl/fdc_xfer_seq_chk.sv
// Protocol checker for the floppy transfer sequencer, bound to the top.
module fdc_xfer_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        irq,
    input logic [15:0] cs_in,
    input logic        cs_wr,
    input logic        db_wr,
    input logic [15:0] wr_data,
    input logic        done_o,
    input logic [3:0]  ctl_state
);
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n) !(cs_wr && db_wr)); // R2
    AST_PARAM_ON_TREQ: assert property (@(posedge clk) disable iff (!rst_n) db_wr |-> cs_in[7]); // R2
    AST_STATE_CODE: assert property (@(posedge clk) disable iff (!rst_n) (ctl_state >= 4'd1) && (ctl_state <= 4'd8)); // R1
    AST_DONE_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> (ctl_state == 4'd8)); // R12
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R10
    AST_INIT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) (cs_wr && wr_data == 16'h4000) |-> (cs_in == 16'h0800 || (irq && ctl_state == 4'd8))); // R8
    AST_CMD_GO_BIT: assert property (@(posedge clk) disable iff (!rst_n) (cs_wr && wr_data != 16'h4000) |-> (wr_data[0] && wr_data[6])); // R11
endmodule

bind fdc_xfer_seq fdc_xfer_seq_chk u_chk (.*);

// File: tb/sim_fdc_xfer_seq.sv
module sim_fdc_xfer_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic        req_drive = 1'b0;
    logic        req_den = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_bytes = '0;
    logic [4:0]  req_sector = '0;
    logic [6:0]  req_track = '0;
    logic        req_ready;
    logic        wdds_arm = 1'b0;
    logic        done_o, done_err, ddmark, dens_dbl, drive_absent;
    logic [3:0]  ctl_state;
    logic [15:0] cs_in;
    logic [15:0] db_in = '0;
    logic        irq = 1'b0;
    logic        cs_wr, db_wr;
    logic [15:0] wr_data;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    fdc_xfer_seq u0 (.*);

    // Behavioural controller: logs writes, raises transfer request 2 cycles after a write
    logic [16:0] wlog [0:63];
    int          wlog_n = 0;
    logic        treq = 1'b0;
    int          tcnt = 0;
    logic        err_f = 1'b0;
    logic        vol_bad = 1'b0;
    int          busy = 0;

    always @(posedge clk) begin
        if (cs_wr || db_wr) begin
            if (wlog_n < 64) wlog[wlog_n] <= {cs_wr, wr_data};
            wlog_n <= wlog_n + 1;
            treq   <= 1'b0;
            tcnt   <= 2;
            if (cs_wr && wr_data == 16'h4000) begin
                vol_bad <= 1'b0;
                busy    <= 3;
            end
        end else begin
            if (tcnt > 0) begin
                tcnt <= tcnt - 1;
                if (tcnt == 1) treq <= 1'b1;
            end
            if (busy > 0) busy <= busy - 1;
        end
    end

    always_comb begin
        if (vol_bad) cs_in = 16'h0800;
        else begin
            cs_in = '0;
            cs_in[15] = err_f;
            cs_in[7]  = treq;
            cs_in[5]  = (busy == 0);
        end
    end

    int base = 0;

    function automatic logic [15:0] cmdw(input logic [2:0] fn, input logic drv,
                                         input logic den, input logic [1:0] ah);
        cmdw = 16'h0041 | (16'(fn) << 1) | (16'(drv) << 4) | (16'(den) << 8) | (16'(ah) << 12);
    endfunction

    task automatic check(input string tag, input logic [16:0] act, input logic [16:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_log(input string tag, input int idx, input logic is_cs, input logic [15:0] d);
        check(tag, wlog[base + idx], {is_cs, d});
    endtask

    task automatic wait_log(input int n);
        int g = 0;
        while (wlog_n < base + n && g < 2000) begin
            @(negedge clk);
            g++;
        end
        if (g >= 2000) begin
            errors++; checks++;
            $display("FAIL wait_log actual=%0d expected=%0d", wlog_n - base, n);
        end
    endtask

    task automatic wait_done(output logic e);
        int g = 0;
        while (!done_o && g < 2000) begin
            @(negedge clk);
            g++;
        end
        if (g >= 2000) begin
            errors++; checks++;
            $display("FAIL wait_done actual=0 expected=1");
        end
        e = done_err;
        @(negedge clk);
    endtask

    task automatic issue(input logic [1:0] op, input logic drv, input logic den,
                         input logic [17:0] a, input logic [15:0] b,
                         input logic [4:0] s, input logic [6:0] t);
        base = wlog_n;
        req_op = op; req_drive = drv; req_den = den; req_addr = a;
        req_bytes = b; req_sector = s; req_track = t;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic fire(input logic [15:0] dv);
        db_in = dv;
        irq = 1'b1;
        @(negedge clk);
        irq = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 reset state", 17'(ctl_state), 17'd8);
        check("R1 reset ready", 17'(req_ready), 17'd1);
        check("R1 reset done", 17'(done_o), 17'd0);
    endtask

    task automatic t_read;
        logic e;
        issue(2'd0, 1'b0, 1'b0, 18'h1_2340, 16'd128, 5'd5, 7'd10);
        wait_log(3);
        chk_log("R11 read cmd word", 0, 1'b1, cmdw(3'd3, 1'b0, 1'b0, 2'b01));
        chk_log("R2 read sector", 1, 1'b0, 16'd5);
        chk_log("R2 read track", 2, 1'b0, 16'd10);
        check("R1 read phase", 17'(ctl_state), 17'd1);
        fire(16'h0040);
        wait_log(6);
        check("R1 empty phase", 17'(ctl_state), 17'd2);
        chk_log("R3 empty cmd", 3, 1'b1, cmdw(3'd1, 1'b0, 1'b0, 2'b01));
        chk_log("R3 empty wcount", 4, 1'b0, 16'd64);
        chk_log("R3 empty addr", 5, 1'b0, 16'h2340);
        fire(16'h0000);
        wait_done(e);
        check("R3 read done ok", 17'(e), 17'd0);
        check("R6 ddmark latched", 17'(ddmark), 17'd1);
        check("R1 back to idle", 17'(ctl_state), 17'd8);
    endtask

    task automatic t_status_dd;
        logic e;
        issue(2'd3, 1'b0, 1'b0, 18'h0, 16'd0, 5'd1, 7'd0);
        wait_log(1);
        chk_log("R9 status cmd", 0, 1'b1, cmdw(3'd5, 1'b0, 1'b0, 2'b00));
        check("R1 status phase", 17'(ctl_state), 17'd6);
        fire(16'h00A0);
        wait_done(e);
        check("R9 status ok", 17'(e), 17'd0);
        check("R9 double density", 17'(dens_dbl), 17'd1);
        check("R9 present", 17'(drive_absent), 17'd0);
    endtask

    task automatic t_write_multi;
        logic e;
        @(negedge clk); wdds_arm = 1'b1; @(negedge clk); wdds_arm = 1'b0;
        issue(2'd1, 1'b1, 1'b0, 18'h0_0100, 16'd300, 5'd26, 7'd3);
        wait_log(3);
        check("R1 fill phase", 17'(ctl_state), 17'd3);
        chk_log("R4 fill cmd", 0, 1'b1, cmdw(3'd0, 1'b1, 1'b1, 2'b00));
        chk_log("R10 fill wcount full", 1, 1'b0, 16'd128);
        chk_log("R4 fill addr", 2, 1'b0, 16'h0100);
        check("R4 no write before fill irq", 17'(wlog_n - base), 17'd3);
        fire(16'h0000);
        wait_log(6);
        check("R1 write phase", 17'(ctl_state), 17'd4);
        chk_log("R5 deleted write cmd", 3, 1'b1, cmdw(3'd6, 1'b1, 1'b1, 2'b00));
        chk_log("R4 write sector", 4, 1'b0, 16'd26);
        chk_log("R4 write track", 5, 1'b0, 16'd3);
        fire(16'h0000);
        wait_log(9);
        check("R10 no done mid request", 17'(done_o), 17'd0);
        chk_log("R10 fill2 wcount", 7, 1'b0, 16'd22);
        chk_log("R10 fill2 addr", 8, 1'b0, 16'h0200);
        fire(16'h0000);
        wait_log(12);
        chk_log("R5 one-shot cleared", 9, 1'b1, cmdw(3'd2, 1'b1, 1'b1, 2'b00));
        chk_log("R10 sector wrap", 10, 1'b0, 16'd1);
        chk_log("R10 track step", 11, 1'b0, 16'd4);
        fire(16'h0000);
        wait_done(e);
        check("R10 write done ok", 17'(e), 17'd0);
    endtask

    task automatic t_format;
        logic e;
        issue(2'd2, 1'b0, 1'b0, 18'h0, 16'd0, 5'd1, 7'd0);
        wait_log(2);
        check("R1 format phase", 17'(ctl_state), 17'd5);
        chk_log("R7 format cmd", 0, 1'b1, cmdw(3'd4, 1'b0, 1'b0, 2'b00));
        chk_log("R7 format key", 1, 1'b0, 16'h0049);
        fire(16'h0000);
        wait_done(e);
        check("R7 format ok", 17'(e), 17'd0);
        check("R7 density from request", 17'(dens_dbl), 17'd0);
    endtask

    task automatic t_status_absent;
        logic e;
        issue(2'd3, 1'b0, 1'b0, 18'h0, 16'd0, 5'd1, 7'd0);
        wait_log(1);
        fire(16'h0020);
        wait_done(e);
        check("R9 absent error", 17'(e), 17'd1);
        check("R9 absent flag", 17'(drive_absent), 17'd1);
        check("R9 density kept", 17'(dens_dbl), 17'd0);
    endtask

    task automatic t_error;
        logic e;
        issue(2'd0, 1'b0, 1'b0, 18'h0, 16'd128, 5'd1, 7'd0);
        wait_log(3);
        err_f = 1'b1;
        fire(16'h0000);
        wait_done(e);
        err_f = 1'b0;
        check("R12 error completion", 17'(e), 17'd1);
        check("R12 idle after error", 17'(ctl_state), 17'd8);
        check("R12 no empty after error", 17'(wlog_n - base), 17'd3);
    endtask

    task automatic t_volume;
        logic e;
        vol_bad = 1'b1;
        @(negedge clk);
        issue(2'd3, 1'b0, 1'b0, 18'h0, 16'd0, 5'd1, 7'd0);
        wait_log(2);
        chk_log("R8 init first", 0, 1'b1, 16'h4000);
        chk_log("R8 command after init", 1, 1'b1, cmdw(3'd5, 1'b0, 1'b0, 2'b00));
        fire(16'h0080);
        wait_done(e);
        check("R8 status ok", 17'(e), 17'd0);
    endtask

    task automatic t_idle_irq;
        base = wlog_n;
        fire(16'h0000);
        @(negedge clk);
        check("R13 init count", 17'(wlog_n - base), 17'd1);
        chk_log("R13 init word", 0, 1'b1, 16'h4000);
        check("R13 stays idle", 17'(ctl_state), 17'd8);
        check("R13 ready again", 17'(req_ready), 17'd1);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read();
        t_status_dd();
        t_write_multi();
        t_format();
        t_status_absent();
        t_error();
        t_volume();
        t_idle_irq();
        finish_run();
    end
endmodule